// File: doc/BRIEF.md
# Dual Pulse and Sawtooth Tone Generator

This block is a three-voice tone source that listens to an 8-bit CPU write bus. Two pulse voices and one sawtooth voice each run their own 12-bit period timer, clocked once per CPU clock. Software writes control, period and enable registers at fixed addresses. The block adds the three voice levels into one unsigned 6-bit sample, which it registers every clock.

Each pulse voice steps through a 16-position sequence. It outputs its 4-bit volume while the position is at or below a 3-bit duty value, or at all times when its force-on mode bit is set. Otherwise it outputs zero.

The sawtooth voice is a small state machine that steps through six states:

- SAW_REST (step 0)
- SAW_RISE1 (step 1)
- SAW_HOLD1 (step 2)
- SAW_RISE2 (step 3)
- SAW_HOLD2 (step 4)
- SAW_RISE3 (step 5)

Every timer reload moves it to the next state:

- REST to RISE1 adds the rate.
- RISE1 to HOLD1 holds.
- HOLD1 to RISE2 adds the rate.
- RISE2 to HOLD2 holds.
- HOLD2 to RISE3 adds the rate.
- RISE3 to REST clears the accumulator. This transition stands for the transient step 6.

The voice contributes the accumulator divided by eight.

Top module: `tri_voice_synth`

## Requirements
- R1: After reset every register, timer, step, state and the accumulator hold zero, and `snd_level` reads 0.
- R2: A write to 0x9000 (first pulse) or 0xA000 (second pulse) sets force-on from bit 7, duty from bits 6:4 and volume from bits 3:0.
- R3: Writes to 0x9001, 0xA001 and 0xB001 set period bits 7:0. Writes to 0x9002, 0xA002 and 0xB002 set the enable from bit 7 and period bits 11:8 from bits 3:0.
- R4: A write to 0xB000 sets the sawtooth rate from bits 5:0.
- R5: On every clock, an enabled voice's timer decrements. When the timer is zero, it instead reloads with the larger of the period and 1, and advances that voice's step.
- R6: A disabled voice keeps its timer and step frozen and contributes 0 to the sum.
- R7: The pulse step counts 0 to 15 and wraps. An enabled pulse outputs its volume when force-on is set or the step is at most the duty value, and outputs 0 otherwise.
- R8: The sawtooth adds its rate to an 8-bit wrapping accumulator on reloads that reach steps 1, 3 and 5. On the reload that reaches step 6 it clears both the accumulator and the step.
- R9: An enabled sawtooth contributes the accumulator shifted right by three, so its level never exceeds 23.
- R10: `snd_level` is a register loaded every clock with the sum of the three voice levels taken from the state before that edge.
- R11: Writes to any other address, including 0x9003, 0xB003 and 0x8000, change nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | CPU clock; all state advances on its rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Write strobe, one clock per write |
| bus_addr | input | 16 | Write address |
| bus_wdata | input | 8 | Write data |
| snd_level | output | 6 | Registered unsigned sum of the voice levels |

## Verification
A wrong timer value in this block shows at `snd_level` as a pulse edge or sawtooth stair that arrives early or late. That error appears at the first reload that differs, so within one period plus two clocks. A wrong pulse step or sawtooth state changes the level within one step, and the sawtooth's stair values expose a skipped or doubled add by the next reload. A disabled voice that keeps clocking shows only after it is re-enabled, as a phase offset. The bench therefore re-enables voices and compares against a cycle-accurate model.

// File: rtl/tvs_pkg.sv
package tvs_pkg;
    localparam int ADDR_W   = 16;
    localparam int DATA_W   = 8;
    localparam int PERIOD_W = 12;
    localparam int VOL_W    = 4;
    localparam int DUTY_W   = 3;
    localparam int PSTEP_W  = 4;
    localparam int RATE_W   = 6;
    localparam int ACC_W    = 8;
    localparam int ACC_SHIFT = 3;
    localparam int SAW_LVL_W = ACC_W - ACC_SHIFT;

    typedef struct packed {
        logic                force_on;
        logic [DUTY_W-1:0]   duty;
        logic [VOL_W-1:0]    vol;
        logic                en;
        logic [PERIOD_W-1:0] period;
    } pulse_cfg_t;

    typedef struct packed {
        logic [RATE_W-1:0]   rate;
        logic                en;
        logic [PERIOD_W-1:0] period;
    } saw_cfg_t;

    typedef enum logic [2:0] {
        SAW_REST  = 3'd0,
        SAW_RISE1 = 3'd1,
        SAW_HOLD1 = 3'd2,
        SAW_RISE2 = 3'd3,
        SAW_HOLD2 = 3'd4,
        SAW_RISE3 = 3'd5
    } saw_state_t;
endpackage

// File: rtl/tvs_regfile.sv
module tvs_regfile
    import tvs_pkg::*;
#(
    parameter int                NUM_PULSE  = 2,
    parameter logic [ADDR_W-1:0] FIRST_BASE = 16'h9000,
    parameter logic [ADDR_W-1:0] STRIDE     = 16'h1000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output pulse_cfg_t        pulse_cfg [NUM_PULSE],
    output saw_cfg_t          saw_cfg
);
    localparam logic [ADDR_W-1:0] SAW_BASE = ADDR_W'(FIRST_BASE + NUM_PULSE * STRIDE);

    for (genvar g = 0; g < NUM_PULSE; g++) begin : g_pulse_regs
        localparam logic [ADDR_W-1:0] BASE = ADDR_W'(FIRST_BASE + g * STRIDE);
        pulse_cfg_t cfg_q;
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                cfg_q <= '0;
            end else if (wr) begin
                if (addr == BASE) begin
                    cfg_q.force_on <= wdata[7];
                    cfg_q.duty     <= wdata[6:4];
                    cfg_q.vol      <= wdata[3:0];
                end else if (addr == BASE + 16'd1) begin
                    cfg_q.period[7:0] <= wdata;
                end else if (addr == BASE + 16'd2) begin
                    cfg_q.en            <= wdata[7];
                    cfg_q.period[11:8]  <= wdata[3:0];
                end
            end
        end
        assign pulse_cfg[g] = cfg_q;
    end

    saw_cfg_t saw_q;
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            saw_q <= '0;
        end else if (wr) begin
            if (addr == SAW_BASE) begin
                saw_q.rate <= wdata[RATE_W-1:0];
            end else if (addr == SAW_BASE + 16'd1) begin
                saw_q.period[7:0] <= wdata;
            end else if (addr == SAW_BASE + 16'd2) begin
                saw_q.en           <= wdata[7];
                saw_q.period[11:8] <= wdata[3:0];
            end
        end
    end
    assign saw_cfg = saw_q;
endmodule

// File: rtl/tvs_period_timer.sv
module tvs_period_timer
    import tvs_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                run,
    input  logic [PERIOD_W-1:0] period,
    output logic                tick
);
    logic [PERIOD_W-1:0] cnt_q;
    logic [PERIOD_W-1:0] reload;

    assign reload = (period == '0) ? PERIOD_W'(1) : period;
    assign tick   = run && (cnt_q == '0);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (run) begin
            if (cnt_q == '0) cnt_q <= reload;
            else             cnt_q <= cnt_q - PERIOD_W'(1);
        end
    end

    assert_reload_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (run && cnt_q == '0) |=> (cnt_q != '0 && cnt_q == (($past(period) == '0) ? PERIOD_W'(1) : $past(period))));
    assert_frozen_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> $stable(cnt_q));
endmodule

// File: rtl/tvs_pulse_voice.sv
module tvs_pulse_voice
    import tvs_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  pulse_cfg_t       cfg,
    output logic [VOL_W-1:0] level
);
    logic               tick;
    logic [PSTEP_W-1:0] step_q;

    tvs_period_timer u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .run    (cfg.en),
        .period (cfg.period),
        .tick   (tick)
    );

    always_ff @(posedge clk) begin
        if (!rst_n)    step_q <= '0;
        else if (tick) step_q <= step_q + PSTEP_W'(1);
    end

    always_comb begin
        if (cfg.en && (cfg.force_on || step_q <= PSTEP_W'(cfg.duty))) level = cfg.vol;
        else                                                          level = '0;
    end

    assert_step_advance_R7: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> step_q == PSTEP_W'($past(step_q) + 1));
    assert_step_frozen_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg.en |=> $stable(step_q));
endmodule

// File: rtl/tvs_saw_voice.sv
module tvs_saw_voice
    import tvs_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  saw_cfg_t             cfg,
    output logic [SAW_LVL_W-1:0] level
);
    logic            tick;
    saw_state_t      state_q, state_d;
    logic [ACC_W-1:0] acc_q;

    tvs_period_timer u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .run    (cfg.en),
        .period (cfg.period),
        .tick   (tick)
    );

    always_comb begin
        state_d = state_q;
        if (tick) begin
            unique case (state_q)
                SAW_REST:  state_d = SAW_RISE1;
                SAW_RISE1: state_d = SAW_HOLD1;
                SAW_HOLD1: state_d = SAW_RISE2;
                SAW_RISE2: state_d = SAW_HOLD2;
                SAW_HOLD2: state_d = SAW_RISE3;
                SAW_RISE3: state_d = SAW_REST;
                default:   state_d = SAW_REST;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= SAW_REST;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q <= '0;
        end else if (tick) begin
            unique case (state_q)
                SAW_REST, SAW_HOLD1, SAW_HOLD2: acc_q <= acc_q + ACC_W'(cfg.rate);
                SAW_RISE3:                      acc_q <= '0;
                default:                        acc_q <= acc_q;
            endcase
        end
    end

    assign level = cfg.en ? acc_q[ACC_W-1:ACC_SHIFT] : '0;

    assert_wrap_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && state_q == SAW_RISE3) |=> (acc_q == '0 && state_q == SAW_REST));
    assert_rest_empty_R8: assert property (@(posedge clk) disable iff (!rst_n)
        state_q == SAW_REST |-> acc_q == '0);
    assert_idle_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg.en |=> ($stable(acc_q) && $stable(state_q)));
endmodule

// File: rtl/tri_voice_synth.sv
module tri_voice_synth
    import tvs_pkg::*;
#(
    parameter int NUM_PULSE = 2,
    parameter int OUT_W     = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [15:0]       bus_addr,
    input  logic [7:0]        bus_wdata,
    output logic [OUT_W-1:0]  snd_level
);
    localparam int MAX_LEVEL = NUM_PULSE * ((1 << VOL_W) - 1) + (((1 << ACC_W) - 1) >> ACC_SHIFT);

    pulse_cfg_t             pulse_cfg [NUM_PULSE];
    saw_cfg_t               saw_cfg;
    logic [VOL_W-1:0]       pulse_lvl [NUM_PULSE];
    logic [SAW_LVL_W-1:0]   saw_lvl;
    logic [OUT_W-1:0]       sum_d;
    logic [OUT_W-1:0]       level_q;

    tvs_regfile #(.NUM_PULSE(NUM_PULSE)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr        (bus_wr),
        .addr      (bus_addr),
        .wdata     (bus_wdata),
        .pulse_cfg (pulse_cfg),
        .saw_cfg   (saw_cfg)
    );

    for (genvar g = 0; g < NUM_PULSE; g++) begin : g_pulse
        tvs_pulse_voice u_voice (
            .clk   (clk),
            .rst_n (rst_n),
            .cfg   (pulse_cfg[g]),
            .level (pulse_lvl[g])
        );
    end

    tvs_saw_voice u_saw (
        .clk   (clk),
        .rst_n (rst_n),
        .cfg   (saw_cfg),
        .level (saw_lvl)
    );

    always_comb begin
        sum_d = OUT_W'(saw_lvl);
        for (int i = 0; i < NUM_PULSE; i++) sum_d = sum_d + OUT_W'(pulse_lvl[i]);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) level_q <= '0;
        else        level_q <= sum_d;
    end

    assign snd_level = level_q;

    assert_level_range_R10: assert property (@(posedge clk) disable iff (!rst_n)
        32'(snd_level) <= MAX_LEVEL);
    assert_saw_ceiling_R9: assert property (@(posedge clk) disable iff (!rst_n)
        32'(saw_lvl) <= 23);
    assert_silent_after_off_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!saw_cfg.en && !pulse_cfg[0].en && !pulse_cfg[1].en) |=> snd_level == '0);
endmodule

// File: tb/tri_voice_synth_tb_top.sv
module tri_voice_synth_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [15:0] bus_addr = '0;
    logic [7:0]  bus_wdata = '0;
    logic [5:0]  snd_level;

    int errors = 0;
    int checks = 0;
    bit done = 0;
    string cur_tag = "R1";
    int exp_q[$];

    always #2 clk = ~clk;

    tri_voice_synth dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .snd_level (snd_level)
    );

    // reference model state
    bit m_pf[2];
    int m_pd[2], m_pv[2], m_pper[2], m_pcnt[2], m_pstep[2];
    bit m_pen[2];
    int m_srate, m_sper, m_scnt, m_sstep, m_sacc;
    bit m_sen;

    function automatic int plvl(int i);
        return (m_pen[i] && (m_pf[i] || m_pstep[i] <= m_pd[i])) ? m_pv[i] : 0;
    endfunction

    task automatic check(int actual, int expected, string tag);
        checks++;
        if (actual != expected) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d at %0t", tag, actual, expected, $time);
        end
    endtask

    // model: predicts value loaded into snd_level at this edge, then advances
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 2; i++) begin
                m_pf[i] = 0; m_pd[i] = 0; m_pv[i] = 0; m_pper[i] = 0;
                m_pcnt[i] = 0; m_pstep[i] = 0; m_pen[i] = 0;
            end
            m_srate = 0; m_sper = 0; m_scnt = 0; m_sstep = 0; m_sacc = 0; m_sen = 0;
        end else begin
            exp_q.push_back(plvl(0) + plvl(1) + (m_sen ? (m_sacc >> 3) : 0));
            for (int i = 0; i < 2; i++) begin
                if (m_pen[i]) begin
                    if (m_pcnt[i] == 0) begin
                        m_pcnt[i] = (m_pper[i] == 0) ? 1 : m_pper[i];
                        m_pstep[i] = (m_pstep[i] + 1) % 16;
                    end else m_pcnt[i]--;
                end
            end
            if (m_sen) begin
                if (m_scnt == 0) begin
                    m_scnt = (m_sper == 0) ? 1 : m_sper;
                    m_sstep++;
                    if (m_sstep == 1 || m_sstep == 3 || m_sstep == 5) m_sacc = (m_sacc + m_srate) % 256;
                    if (m_sstep == 6) begin m_sacc = 0; m_sstep = 0; end
                end else m_scnt--;
            end
            if (bus_wr) begin
                for (int i = 0; i < 2; i++) begin
                    if (bus_addr == 16'h9000 + 16'(i * 16'h1000)) begin
                        m_pf[i] = bus_wdata[7]; m_pd[i] = int'(bus_wdata[6:4]); m_pv[i] = int'(bus_wdata[3:0]);
                    end
                    if (bus_addr == 16'h9001 + 16'(i * 16'h1000)) m_pper[i] = (m_pper[i] & 'hF00) | int'(bus_wdata);
                    if (bus_addr == 16'h9002 + 16'(i * 16'h1000)) begin
                        m_pen[i] = bus_wdata[7]; m_pper[i] = (m_pper[i] & 'hFF) | (int'(bus_wdata[3:0]) << 8);
                    end
                end
                if (bus_addr == 16'hB000) m_srate = int'(bus_wdata[5:0]);
                if (bus_addr == 16'hB001) m_sper = (m_sper & 'hF00) | int'(bus_wdata);
                if (bus_addr == 16'hB002) begin
                    m_sen = bus_wdata[7]; m_sper = (m_sper & 'hFF) | (int'(bus_wdata[3:0]) << 8);
                end
            end
        end
    end

    // monitor: scoreboard compare away from the active edge
    always @(negedge clk) begin
        if (rst_n && exp_q.size() > 0) check(int'(snd_level), exp_q.pop_front(), {cur_tag, " R10 scoreboard"});
    end

    task automatic wr(input logic [15:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        int hi;
        int lo;
        repeat (3) @(negedge clk);
        check(int'(snd_level), 0, "R1 reset level");
        rst_n = 1'b1;
        idle(2);
        check(int'(snd_level), 0, "R1 idle after reset");

        cur_tag = "R2";
        wr(16'h9000, 8'h8F);
        wr(16'h9002, 8'h80);
        idle(3);
        check(int'(snd_level), 15, "R2 force-on full volume");

        cur_tag = "R7";
        wr(16'h9000, 8'h38);
        wr(16'h9001, 8'h03);
        idle(150);

        cur_tag = "R3";
        wr(16'hA000, 8'h7A);
        wr(16'hA001, 8'h05);
        wr(16'hA002, 8'h81);
        idle(600);

        cur_tag = "R11";
        wr(16'h9003, 8'hFF);
        wr(16'hB003, 8'hFF);
        wr(16'h8000, 8'hFF);
        wr(16'hA003, 8'h00);
        idle(60);

        cur_tag = "R6";
        wr(16'h9002, 8'h00);
        wr(16'hA002, 8'h01);
        idle(4);
        check(int'(snd_level), 0, "R6 disabled pulses silent");
        idle(50);
        wr(16'h9002, 8'h80);
        wr(16'hA002, 8'h81);
        idle(200);

        cur_tag = "R8";
        wr(16'h9002, 8'h00);
        wr(16'hA002, 8'h00);
        wr(16'hB000, 8'hFF);
        wr(16'hB001, 8'h00);
        wr(16'hB002, 8'h80);
        hi = 0; lo = 99;
        for (int k = 0; k < 60; k++) begin
            @(negedge clk);
            if (int'(snd_level) > hi) hi = int'(snd_level);
            if (int'(snd_level) < lo) lo = int'(snd_level);
        end
        check(hi, 23, "R9 sawtooth peak with rate 63");
        check(lo, 0, "R8 sawtooth returns to zero");

        cur_tag = "R4";
        wr(16'hB000, 8'h2A);
        wr(16'hB001, 8'h07);
        idle(300);

        cur_tag = "R5";
        wr(16'h9000, 8'h10);
        wr(16'h9001, 8'h00);
        wr(16'h9002, 8'h82);
        wr(16'hA000, 8'hC5);
        wr(16'hA001, 8'h00);
        wr(16'hA002, 8'h80);
        idle(1500);

        cur_tag = "R6";
        wr(16'hB002, 8'h07);
        idle(40);
        wr(16'hB002, 8'h80);
        idle(200);

        cur_tag = "R1";
        @(negedge clk);
        rst_n = 1'b0;
        exp_q.delete();
        @(negedge clk);
        @(negedge clk);
        check(int'(snd_level), 0, "R1 level cleared by reset");
        rst_n = 1'b1;
        wr(16'h9002, 8'h80);
        idle(3);
        check(int'(snd_level), 0, "R1 volume cleared by reset");

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #(4 * 200000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule